// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

This block is a three-stage multi-mode register placed between two combinational logic clouds so that one set of flops can do several test jobs. Two mode inputs pick the job on every clock edge. In normal mode it is an ordinary pipeline register. In scan mode the stages form a shift chain from a serial input to a serial output. In the linear-feedback mode it either walks through a pseudo-random sequence of patterns or compresses the data on its parallel inputs into a signature. A fourth mode clears the register.

The stages are S0, S1 and S2, chained in that order. S0 is the head of the chain, and a multiplexer there picks the serial input in scan mode and the XOR feedback otherwise. The parallel output carries S0 on bit 0, S1 on bit 1 and S2 on bit 2. The serial output is always S2. A test controller outside the block sets the mode bits, seeds the register and keeps the reference signatures.

Top module: `bilbo_reg`

## Requirements
- R1: With mode_b1=1 and mode_b0=1 (normal), each stage loads its par_in bit on the clock edge, so par_out equals the previous par_in.
- R2: With mode_b1=0 and mode_b0=0 (scan), par_out[0] takes scan_in and par_out[i] takes the old par_out[i-1] on each edge.
- R3: scan_out always equals par_out[2] (stage S2), in every mode. A bit that enters through scan_in appears on scan_out three edges later.
- R4: With mode_b1=1 and mode_b0=0 (clear), all stages become 0 on the clock edge, whatever par_in holds.
- R5: Reset is synchronous and active low. With rst_n=0, par_out becomes 0 on the next edge, and this takes priority over every mode.
- R6: With mode_b1=0 and mode_b0=1 (feedback) and par_in=0, S0 takes the old S1 XOR S2, S1 takes the old S0, and S2 takes the old S1.
- R7: In feedback mode with par_in=0 and a start of S0S1S2=100, the states are 100, 010, 101, 110, 111, 011, 001, and then 100 again.
- R8: In feedback mode with par_in=0, the all-zero state is kept forever, and a nonzero state never reaches zero.
- R9: In feedback mode with a nonzero par_in, each stage also XORs in its own par_in bit (S0 takes S1^S2^par_in[0], Si takes S(i-1)^par_in[i]). A fixed input stream therefore gives a signature that is known in advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_b0 | input | 1 | Mode select, low bit |
| mode_b1 | input | 1 | Mode select, high bit |
| par_in | input | 3 | Parallel data from the upstream logic; bit i feeds stage Si |
| scan_in | input | 1 | Serial input to the head of the chain |
| scan_out | output | 1 | Serial output, always stage S2 |
| par_out | output | 3 | Parallel register contents; bit i is stage Si |

## Verification
The bench steps every start state through the feedback mode and checks the seven-state cycle. A wrong tap or a reversed chain would give a short cycle or a different order. It holds the register at zero in pattern mode to show that the lock-up state is kept, and it sweeps all state and data pairs for signature compression, because a stage that dropped its data XOR would give the wrong signature. It also checks that the serial output follows a scanned bit with a delay of exactly three edges, and that reset wins over the normal mode with data present. A design whose mode decode had two modes swapped would fail at least one of these checks.

// File: rtl/bilbo_pkg.sv
// Package: shared mode type and decode for the observer register.
// Assumes the mode pair is presented as {b1, b0}.
package bilbo_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN  = 2'b00,
        MODE_LFSR  = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_LOAD  = 2'b11
    } bilbo_mode_e;

    // Maps the raw mode pins onto the named mode.
    function automatic bilbo_mode_e decode_mode(input logic b1, input logic b0);
        bilbo_mode_e m;
        case ({b1, b0})
            2'b00:   m = MODE_SCAN;
            2'b01:   m = MODE_LFSR;
            2'b10:   m = MODE_CLEAR;
            default: m = MODE_LOAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bilbo_head_mux.sv
// Module: chain-head select. Gives the serial input in scan mode and the
// XOR of the two tail taps in every other mode.
// Assumes the caller passes the last two stages as the taps.
module bilbo_head_mux
    import bilbo_pkg::*;
(
    input  bilbo_mode_e mode,
    input  logic        scan_in,
    input  logic        tap_hi,
    input  logic        tap_lo,
    output logic        head
);

    logic feedback;

    // Linear feedback from the tail taps.
    always_comb feedback = tap_hi ^ tap_lo;

    // Picks the source of the chain head.
    always_comb head = (mode == MODE_SCAN) ? scan_in : feedback;

endmodule

// File: rtl/bilbo_stage.sv
// Module: one stage of the register. The next value depends on the mode:
// the parallel bit, the chain bit, their XOR, or zero.
// Assumes a synchronous active-low reset that takes priority over the mode.
module bilbo_stage
    import bilbo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bilbo_mode_e mode,
    input  logic        chain_in,
    input  logic        par_bit,
    output logic        q
);

    logic nxt;

    // Selects the next stage value by mode.
    always_comb begin
        case (mode)
            MODE_LOAD:  nxt = par_bit;
            MODE_SCAN:  nxt = chain_in;
            MODE_LFSR:  nxt = chain_in ^ par_bit;
            default:    nxt = 1'b0;
        endcase
    end

    // Stage flop with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

endmodule

// File: rtl/bilbo_reg.sv
// Module: multi-mode test register (normal, scan, feedback, clear).
// Stage 0 is the chain head and the last stage drives scan_out.
// Assumes WIDTH >= 2. The feedback taps are fixed to the last two stages,
// which gives a maximal-length sequence at the default width of 3.
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_b0,
    input  logic             mode_b1,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic             scan_out,
    output logic [WIDTH-1:0] par_out
);

    localparam int TAP_HI = WIDTH - 1;
    localparam int TAP_LO = WIDTH - 2;

    bilbo_mode_e      mode;
    logic             head;
    logic [WIDTH-1:0] chain;
    logic [WIDTH-1:0] state;

    // Decodes the mode pins once for all stages.
    always_comb mode = decode_mode(mode_b1, mode_b0);

    bilbo_head_mux u_head (
        .mode    (mode),
        .scan_in (scan_in),
        .tap_hi  (state[TAP_HI]),
        .tap_lo  (state[TAP_LO]),
        .head    (head)
    );

    // Chain wiring: the head feeds stage 0 and each stage feeds the next.
    always_comb chain[0] = head;

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_link
            always_comb chain[i] = state[i-1];
        end
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            bilbo_stage u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (mode),
                .chain_in (chain[i]),
                .par_bit  (par_in[i]),
                .q        (state[i])
            );
        end
    endgenerate

    // Drives the outputs from the stage flops.
    always_comb par_out  = state;
    always_comb scan_out = state[TAP_HI];

endmodule

// File: rtl/bilbo_reg_chk.sv
// Checker: properties of the observer register seen at its ports.
module bilbo_reg_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_b0,
    input logic             mode_b1,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic             scan_out,
    input logic [WIDTH-1:0] par_out
);

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b1 && mode_b0) |=> par_out == $past(par_in));

    assert_scan_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && !mode_b0) |=>
            (par_out[0] == $past(scan_in)) &&
            (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0])));

    assert_scan_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && !mode_b0) |=> scan_out == $past(par_out[WIDTH-2]));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b1 && !mode_b0) |=> par_out == '0);

    assert_feedback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0) |=>
            par_out[0] == $past(par_out[WIDTH-1] ^ par_out[WIDTH-2] ^ par_in[0]));

    assert_signature_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0) |=>
            par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0] ^ par_in[WIDTH-1:1]));

    assert_lockup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0 && par_in == '0 && par_out != '0) |=> par_out != '0);

endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_b0  (mode_b0),
    .mode_b1  (mode_b1),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .par_out  (par_out)
);

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_b0 = 1'b0;
    logic       mode_b1 = 1'b0;
    logic [2:0] par_in = '0;
    logic       scan_in = 1'b0;
    logic       scan_out;
    logic [2:0] par_out;

    int n_chk = 0;
    int n_bad = 0;

    bilbo_reg #(.WIDTH(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_b0(mode_b0), .mode_b1(mode_b1),
        .par_in(par_in), .scan_in(scan_in), .scan_out(scan_out), .par_out(par_out)
    );

    always #4 clk = ~clk;

    // Mode codes as {b1,b0}.
    localparam logic [1:0] M_SCAN = 2'b00, M_FB = 2'b01, M_CLR = 2'b10, M_LOAD = 2'b11;

    // Drives the inputs at the falling edge, then waits just past the next rising edge.
    task automatic step(input logic rn, input logic [1:0] m, input logic [2:0] d, input logic si);
        @(negedge clk);
        rst_n = rn; mode_b1 = m[1]; mode_b0 = m[0]; par_in = d; scan_in = si;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Reference next state for feedback mode, computed from the bit equations.
    function automatic logic [2:0] fb_next(input logic [2:0] s, input logic [2:0] d);
        int b0, b1, b2;
        b0 = (int'(s[1]) + int'(s[2]) + int'(d[0])) % 2;
        b1 = (int'(s[0]) + int'(d[1])) % 2;
        b2 = (int'(s[1]) + int'(d[2])) % 2;
        return 3'(b2 * 4 + b1 * 2 + b0);
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] sh;
        logic [2:0] sig;
        logic [2:0] seq [0:7];
        seq = '{3'b100, 3'b010, 3'b101, 3'b110, 3'b111, 3'b011, 3'b001, 3'b100};

        // R5: reset state.
        step(1'b0, M_LOAD, 3'b101, 1'b1);
        check("R5 reset", par_out, 3'b000);
        check("R3 reset scan_out", {2'b0, scan_out}, 3'b000);

        // R1/R3: normal capture over all data values.
        for (int v = 0; v < 8; v++) begin
            step(1'b1, M_LOAD, 3'(v), 1'b0);
            check("R1 load", par_out, 3'(v));
            check("R3 scan_out=S2", {2'b0, scan_out}, {2'b0, 1'(v >> 2)});
        end

        // R5: reset wins over normal mode with data present.
        step(1'b1, M_LOAD, 3'b111, 1'b0);
        step(1'b0, M_LOAD, 3'b101, 1'b0);
        check("R5 reset priority", par_out, 3'b000);

        // R4: clear from every preload, with par_in nonzero.
        for (int v = 0; v < 8; v++) begin
            step(1'b1, M_LOAD, 3'(v), 1'b0);
            step(1'b1, M_CLR, 3'b111, 1'b1);
            check("R4 clear", par_out, 3'b000);
        end

        // R2/R3: scan shift of a bit stream, with par_in held at an unrelated value.
        sh = 3'b000;
        for (int k = 0; k < 10; k++) begin
            logic b;
            b = logic'((32'h2D5 >> k) & 1);
            step(1'b1, M_SCAN, 3'b110, b);
            sh = {sh[1:0], b};
            check("R2 scan shift", par_out, sh);
            check("R3 scan_out", {2'b0, scan_out}, {2'b0, sh[2]});
        end

        // R3: a single one travels to scan_out on the third edge.
        step(1'b1, M_CLR, 3'b000, 1'b0);
        step(1'b1, M_SCAN, 3'b000, 1'b1);
        step(1'b1, M_SCAN, 3'b000, 1'b0);
        check("R3 delay edge2", {2'b0, scan_out}, 3'b000);
        step(1'b1, M_SCAN, 3'b000, 1'b0);
        check("R3 delay edge3", {2'b0, scan_out}, 3'b001);

        // R6: one feedback step from every start state.
        for (int v = 0; v < 8; v++) begin
            logic [2:0] s;
            s = 3'(v);
            step(1'b1, M_LOAD, s, 1'b0);
            step(1'b1, M_FB, 3'b000, 1'b0);
            check("R6 feedback step", par_out, {s[1], s[0], s[1] ^ s[2]});
        end

        // R7: seven-state cycle from S0S1S2=100 (par_out bit i is Si).
        step(1'b1, M_LOAD, 3'b001, 1'b0);
        for (int k = 1; k < 8; k++) begin
            step(1'b1, M_FB, 3'b000, 1'b0);
            check("R7 sequence", par_out, {seq[k][0], seq[k][1], seq[k][2]});
        end

        // R8: the zero state is kept.
        step(1'b1, M_CLR, 3'b000, 1'b0);
        for (int k = 0; k < 5; k++) begin
            step(1'b1, M_FB, 3'b000, 1'b0);
            check("R8 lockup", par_out, 3'b000);
        end

        // R9: every state and data pair for one compression step.
        for (int v = 0; v < 8; v++) begin
            for (int d = 0; d < 8; d++) begin
                step(1'b1, M_LOAD, 3'(v), 1'b0);
                step(1'b1, M_FB, 3'(d), 1'b0);
                check("R9 signature step", par_out, fb_next(3'(v), 3'(d)));
            end
        end

        // R9: signature of a fixed stream from a cleared start.
        step(1'b1, M_CLR, 3'b000, 1'b0);
        sig = 3'b000;
        for (int k = 0; k < 12; k++) begin
            logic [2:0] d;
            d = 3'((k * 5 + 3) % 8);
            step(1'b1, M_FB, d, 1'b0);
            sig = fb_next(sig, d);
        end
        check("R9 stream signature", par_out, sig);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule